// File: doc/BRIEF.md
# Overflow-Status Host Port

This block connects an 8-bit asynchronous processor bus to the system clock domain of a conferencing engine. The chip select, read strobe, write strobe, command-select line and data byte pass through synchronisers. The block finds the strobe edges in the clock domain and acts on them. A write becomes either an instruction byte or an operand byte. The command-select level at the moment of the write decides which.

On a read, the same command-select line picks one of two status bytes. One byte holds the overflow flags of the first eight conference channels. The other holds the flags of the last two channels. The flags are sticky. Each one is set by an event from the datapath and is cleared when the byte that holds it is read.

After a synchronous reset, the block waits a fixed number of frame pulses before it lets the bus drivers or the serial output driver turn on. Both drivers also stay off for as long as reset is held.

Top module: `hostPort`

## Requirements
- R1: `busOe` is 0 while `rstN` is low, while `selN` is high, and whenever no read is in progress. `busOut` is 0 whenever `busOe` is 0.
- R2: A write with `cmdSel` high stores the byte in `opcode` and gives exactly one `opcodeValid` pulse. No `dataValid` pulse is produced.
- R3: A write with `cmdSel` low stores the byte in `wrData` and gives exactly one `dataValid` pulse. No `opcodeValid` pulse is produced.
- R4: The byte that is stored is the `busIn` value present when `wrN` rises. The bus must be held for at least three clock cycles after that edge.
- R5: A read starts driving the bus no more than three clock cycles after `rdN` falls. The bus is released no more than three cycles after `rdN` rises.
- R6: A read with `cmdSel` low returns the flags of channels 1 to 8. Channel 1 (`ovfSet[0]`) is in bit 0 and channel 8 is in bit 7.
- R7: A read with `cmdSel` high returns channel 9 in bit 0 and channel 10 in bit 1. Bits 7 to 2 read as 0.
- R8: The flags are active high. Each flag is set by a one-cycle pulse on its `ovfSet` bit and stays set until it is read. A read clears only the flags of the byte it returned.
- R9: `rstN` is sampled on the rising clock edge. After it is released, `ready`, `busOe` and `serialOe` stay 0 until two `framePulse` cycles have been seen. Bus transfers made during that time have no effect.
- R10: `serialOe` equals `ready && serialReq`, and it is 0 while `rstN` is low.
- R11: A strobe given while `selN` is high has no effect. A write gives no valid pulse. A read does not drive the bus and does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| framePulse | input | 1 | One-cycle frame marker |
| selN | input | 1 | Chip select, active low, asynchronous |
| rdN | input | 1 | Read strobe, active low, asynchronous |
| wrN | input | 1 | Write strobe, active low, asynchronous |
| cmdSel | input | 1 | Selects instruction or operand on a write; selects the status byte on a read |
| busIn | input | 8 | Byte from the processor |
| busOut | output | 8 | Byte returned to the processor |
| busOe | output | 1 | Enable for the data bus driver |
| ovfSet | input | 10 | Per-channel overflow event, bit k is channel k+1 |
| serialReq | input | 1 | Request from the datapath to drive the serial output |
| serialOe | output | 1 | Enable for the serial output driver |
| opcode | output | 8 | Last instruction byte written |
| opcodeValid | output | 1 | One-cycle pulse when `opcode` is updated |
| wrData | output | 8 | Last operand byte written |
| dataValid | output | 1 | One-cycle pulse when `wrData` is updated |
| ready | output | 1 | Initialization finished |

## Verification
All 256 byte values are written once as instructions and once as operands. This separates the two write destinations and shows that every bit of the bus is captured. Each of the ten channels is raised on its own and then read through both status bytes, which exposes any error in bit position or byte steering. A mixed pattern is then set and only one byte is read, which shows that the clear touches only that byte. Strobes given with chip select high, and strobes given before the second frame pulse, separate a working gate from a missing one.

// File: rtl/hostPortPkg.sv
package hostPortPkg;
  typedef struct packed {
    logic opcodeLoad;
    logic dataLoad;
    logic readLoad;
    logic readHigh;
  } portStrobes_t;
endpackage

// File: rtl/hostPortCtrl.sv
module hostPortCtrl
  import hostPortPkg::*;
#(
  parameter int SYNC_DEPTH  = 2,
  parameter int INIT_FRAMES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         framePulse,
  input  logic         selN,
  input  logic         rdN,
  input  logic         wrN,
  input  logic         cmdSel,
  output portStrobes_t strobes,
  output logic         ready,
  output logic         rdActive
);
  localparam int CW = $clog2(INIT_FRAMES + 1);
  localparam logic [3:0] IDLE_LEVELS = 4'b0111; // {cmd, wrN, rdN, selN}

  logic [SYNC_DEPTH-1:0][3:0] syncQ;
  logic selS, rdS, wrS, cmdS;
  logic prevRd, prevWr;
  logic wrRise, rdFall, accessOk;
  logic [CW-1:0] frameCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= {SYNC_DEPTH{IDLE_LEVELS}};
    end else begin
      syncQ[0] <= {cmdSel, wrN, rdN, selN};
      for (int i = 1; i < SYNC_DEPTH; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign selS = syncQ[SYNC_DEPTH-1][0];
  assign rdS  = syncQ[SYNC_DEPTH-1][1];
  assign wrS  = syncQ[SYNC_DEPTH-1][2];
  assign cmdS = syncQ[SYNC_DEPTH-1][3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRd <= 1'b1;
      prevWr <= 1'b1;
    end else begin
      prevRd <= rdS;
      prevWr <= wrS;
    end
  end

  assign wrRise   = wrS & ~prevWr;
  assign rdFall   = ~rdS & prevRd;
  assign accessOk = ready & ~selS;

  always_comb begin
    strobes.opcodeLoad = wrRise & accessOk & cmdS;
    strobes.dataLoad   = wrRise & accessOk & ~cmdS;
    strobes.readLoad   = rdFall & accessOk;
    strobes.readHigh   = cmdS;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     rdActive <= 1'b0;
    else if (rdS || selS || !ready) rdActive <= 1'b0;
    else if (strobes.readLoad)     rdActive <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      ready    <= 1'b0;
    end else if (!ready && framePulse) begin
      if (frameCnt == CW'(INIT_FRAMES - 1)) ready <= 1'b1;
      else frameCnt <= frameCnt + 1'b1;
    end
  end

  // R1: the bus driver may only be on for a selected port after initialization
  assert_drive_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdActive |-> (ready && !selS));
  // R9: once ready, stays ready until the next reset
  assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);
  // R2/R3: a single write can never be steered to both destinations
  assert_one_dest_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.opcodeLoad && strobes.dataLoad));
endmodule

// File: rtl/hostPortData.sv
module hostPortData
  import hostPortPkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int CHANNELS   = 10,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobes_t        strobes,
  input  logic [WIDTH-1:0]    busIn,
  input  logic [CHANNELS-1:0] ovfSet,
  output logic [WIDTH-1:0]    readReg,
  output logic [WIDTH-1:0]    opcode,
  output logic                opcodeValid,
  output logic [WIDTH-1:0]    wrData,
  output logic                dataValid
);
  localparam int HI_BITS = CHANNELS - WIDTH;
  localparam int PAD     = 2 * WIDTH - CHANNELS;

  logic [SYNC_DEPTH-1:0][WIDTH-1:0] busQ;
  logic [CHANNELS-1:0] flags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ <= '0;
    end else begin
      busQ[0] <= busIn;
      for (int i = 1; i < SYNC_DEPTH; i++) busQ[i] <= busQ[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode      <= '0;
      wrData      <= '0;
      opcodeValid <= 1'b0;
      dataValid   <= 1'b0;
    end else begin
      opcodeValid <= strobes.opcodeLoad;
      dataValid   <= strobes.dataLoad;
      if (strobes.opcodeLoad) opcode <= busQ[SYNC_DEPTH-1];
      if (strobes.dataLoad)   wrData <= busQ[SYNC_DEPTH-1];
    end
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_flag
    logic clrHit;
    if (ch < WIDTH) begin : g_low
      assign clrHit = strobes.readLoad & ~strobes.readHigh;
    end else begin : g_high
      assign clrHit = strobes.readLoad & strobes.readHigh;
    end
    always_ff @(posedge clk) begin
      if (!rstN)            flags[ch] <= 1'b0;
      else if (ovfSet[ch])  flags[ch] <= 1'b1;
      else if (clrHit)      flags[ch] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) readReg <= '0;
    else if (strobes.readLoad)
      readReg <= strobes.readHigh ? {{PAD{1'b0}}, flags[CHANNELS-1:WIDTH]}
                                  : flags[WIDTH-1:0];
  end

  // R7: a high-byte read never carries anything above the last channel
  assert_high_pad_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readLoad && strobes.readHigh) |=> (readReg[WIDTH-1:HI_BITS] == '0));
  // R8: a low-byte read with no new event leaves the low flags clear
  assert_low_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readLoad && !strobes.readHigh && ovfSet[WIDTH-1:0] == '0)
      |=> (flags[WIDTH-1:0] == '0));
  // R8: a low-byte read leaves the high flags alone
  assert_high_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readLoad && !strobes.readHigh) |=> $stable(flags[CHANNELS-1:WIDTH]) || $past(|ovfSet[CHANNELS-1:WIDTH]));
  // R2: an instruction pulse never coincides with an operand pulse
  assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opcodeValid, dataValid}));
endmodule

// File: rtl/hostPort.sv
module hostPort
  import hostPortPkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int CHANNELS    = 10,
  parameter int SYNC_DEPTH  = 2,
  parameter int INIT_FRAMES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                framePulse,
  input  logic                selN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic                cmdSel,
  input  logic [WIDTH-1:0]    busIn,
  output logic [WIDTH-1:0]    busOut,
  output logic                busOe,
  input  logic [CHANNELS-1:0] ovfSet,
  input  logic                serialReq,
  output logic                serialOe,
  output logic [WIDTH-1:0]    opcode,
  output logic                opcodeValid,
  output logic [WIDTH-1:0]    wrData,
  output logic                dataValid,
  output logic                ready
);
  portStrobes_t strobes;
  logic rdActive;
  logic [WIDTH-1:0] readReg;

  hostPortCtrl #(.SYNC_DEPTH(SYNC_DEPTH), .INIT_FRAMES(INIT_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .selN(selN), .rdN(rdN),
    .wrN(wrN), .cmdSel(cmdSel), .strobes(strobes), .ready(ready), .rdActive(rdActive)
  );

  hostPortData #(.WIDTH(WIDTH), .CHANNELS(CHANNELS), .SYNC_DEPTH(SYNC_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busIn(busIn), .ovfSet(ovfSet),
    .readReg(readReg), .opcode(opcode), .opcodeValid(opcodeValid),
    .wrData(wrData), .dataValid(dataValid)
  );

  assign busOe    = rstN & rdActive;
  assign busOut   = busOe ? readReg : '0;
  assign serialOe = rstN & ready & serialReq;

  // R1: reset always wins over the bus driver
  always_comb begin
    if (!rstN) assert_reset_quiet_R1: assert (!busOe && !serialOe);
  end
  // R10: serial driver only after initialization
  assert_serial_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    serialOe |-> ready);
endmodule

// File: tb/hostPort_tb.sv
module hostPort_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0, framePulse = 1'b0, selN = 1'b1, rdN = 1'b1, wrN = 1'b1, cmdSel = 1'b0;
  logic [7:0] busIn = '0;
  logic [9:0] ovfSet = '0;
  logic serialReq = 1'b0;
  logic [7:0] busOut, opcode, wrData;
  logic busOe, serialOe, opcodeValid, dataValid, ready;

  int vectors = 0, misses = 0;
  int opCnt, dtCnt;
  logic [7:0] lastOp, lastDt;

  always #5 clk = ~clk;

  hostPort u_dut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .selN(selN), .rdN(rdN), .wrN(wrN),
    .cmdSel(cmdSel), .busIn(busIn), .busOut(busOut), .busOe(busOe), .ovfSet(ovfSet),
    .serialReq(serialReq), .serialOe(serialOe), .opcode(opcode), .opcodeValid(opcodeValid),
    .wrData(wrData), .dataValid(dataValid), .ready(ready)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doWrite(input logic sel, input logic cmd, input logic [7:0] v);
    opCnt = 0; dtCnt = 0;
    selN = sel; cmdSel = cmd; busIn = v;
    cyc(2);
    wrN = 1'b0;
    cyc(3);
    wrN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (opcodeValid) begin opCnt++; lastOp = opcode; end
      if (dataValid)   begin dtCnt++; lastDt = wrData; end
    end
    busIn = ~v;
    selN = 1'b1;
    cyc(3);
  endtask

  task automatic doRead(input logic sel, input logic cmd, output logic oe, output logic [7:0] val);
    selN = sel; cmdSel = cmd;
    cyc(2);
    chk("R5 idle before read", {15'd0, busOe}, 16'd0);
    rdN = 1'b0;
    cyc(4);
    oe = busOe; val = busOut;
    rdN = 1'b1;
    cyc(4);
    chk("R5 released after read", {15'd0, busOe}, 16'd0);
    chk("R1 busOut zero when off", {8'd0, busOut}, 16'd0);
    selN = 1'b1;
    cyc(2);
  endtask

  task automatic raise(input logic [9:0] m);
    ovfSet = m;
    @(negedge clk);
    ovfSet = '0;
    @(negedge clk);
  endtask

  initial begin
    cyc(200000);
    misses++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic oe;
    logic [7:0] val;
    serialReq = 1'b1;
    cyc(3);
    chk("R1 reset busOe", {15'd0, busOe}, 16'd0);
    chk("R10 reset serialOe", {15'd0, serialOe}, 16'd0);
    rstN = 1'b1;
    cyc(2);
    chk("R9 not ready after release", {15'd0, ready}, 16'd0);
    // R9: transfers during init are ignored
    doWrite(1'b0, 1'b1, 8'h5A);
    chk("R9 init write ignored", 16'(opCnt + dtCnt), 16'd0);
    raise(10'h001);
    doRead(1'b0, 1'b0, oe, val);
    chk("R9 init read no drive", {15'd0, oe}, 16'd0);
    framePulse = 1'b1; @(negedge clk); framePulse = 1'b0;
    cyc(3);
    chk("R9 one frame not ready", {15'd0, ready}, 16'd0);
    chk("R10 serialOe before ready", {15'd0, serialOe}, 16'd0);
    framePulse = 1'b1; @(negedge clk); framePulse = 1'b0;
    chk("R9 ready after two frames", {15'd0, ready}, 16'd1);
    chk("R10 serialOe on", {15'd0, serialOe}, 16'd1);
    serialReq = 1'b0; #1;
    chk("R10 serialOe follows req", {15'd0, serialOe}, 16'd0);
    // flag set during init is kept: R8 sticky, read clears it
    doRead(1'b0, 1'b0, oe, val);
    chk("R5 bus driven during read", {15'd0, oe}, 16'd1);
    chk("R8 sticky across init", {8'd0, val}, 16'h0001);

    // R2, R3, R4: every byte as opcode and as data
    for (int v = 0; v < 256; v++) begin
      doWrite(1'b0, 1'b1, 8'(v));
      chk("R2 opcode pulses", 16'(opCnt), 16'd1);
      chk("R2 no data pulse", 16'(dtCnt), 16'd0);
      chk("R4 opcode value", {8'd0, lastOp}, 16'(v));
      doWrite(1'b0, 1'b0, 8'(255 - v));
      chk("R3 data pulses", 16'(dtCnt), 16'd1);
      chk("R3 no opcode pulse", 16'(opCnt), 16'd0);
      chk("R4 data value", {8'd0, lastDt}, 16'(255 - v));
      chk("R3 opcode untouched", {8'd0, opcode}, 16'(v));
    end

    // R6, R7, R8: each channel alone
    for (int c = 0; c < 10; c++) begin
      raise(10'(1 << c));
      doRead(1'b0, 1'b0, oe, val);
      chk("R6 low byte", {8'd0, val}, (c < 8) ? 16'(1 << c) : 16'd0);
      doRead(1'b0, 1'b1, oe, val);
      chk("R7 high byte", {8'd0, val}, (c >= 8) ? 16'(1 << (c - 8)) : 16'd0);
      doRead(1'b0, 1'b0, oe, val);
      chk("R8 low cleared", {8'd0, val}, 16'd0);
      doRead(1'b0, 1'b1, oe, val);
      chk("R8 high cleared", {8'd0, val}, 16'd0);
    end

    // R8: selective clear
    raise(10'h3A5);
    doRead(1'b0, 1'b1, oe, val);
    chk("R7 mixed high", {8'd0, val}, 16'h0003);
    raise(10'h200);
    doRead(1'b0, 1'b0, oe, val);
    chk("R8 low kept after high read", {8'd0, val}, 16'h00A5);
    doRead(1'b0, 1'b1, oe, val);
    chk("R8 high reset and re-set", {8'd0, val}, 16'h0002);

    // R11: deselected strobes
    doWrite(1'b1, 1'b1, 8'hC3);
    chk("R11 deselected write", 16'(opCnt + dtCnt), 16'd0);
    chk("R11 opcode kept", {8'd0, opcode}, 16'd255);
    raise(10'h081);
    doRead(1'b1, 1'b0, oe, val);
    chk("R11 deselected read no drive", {15'd0, oe}, 16'd0);
    doRead(1'b0, 1'b0, oe, val);
    chk("R11 flags survive deselected read", {8'd0, val}, 16'h0081);

    // R1: reset mid-read releases the bus at once
    selN = 1'b0; cmdSel = 1'b0; cyc(2); rdN = 1'b0; cyc(4);
    chk("R5 driving before reset", {15'd0, busOe}, 16'd1);
    rstN = 1'b0; #1;
    chk("R1 reset drops busOe", {15'd0, busOe}, 16'd0);
    @(negedge clk);
    chk("R9 reset clears ready", {15'd0, ready}, 16'd0);
    rdN = 1'b1; selN = 1'b1; rstN = 1'b1;
    cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule